// File: doc/BRIEF.md
# Simultaneous-Row Group Discovery Sequencer

This block works out which rows of a DRAM subarray open together when a deliberately too-fast activate, precharge, activate chain is aimed at a chosen pair of rows. After a start command it drives the three commands back to back. While the rows are still open it writes a marker word into every column. It then closes the bank and scans every row of the subarray one at a time, at nominal timing. It compares each word read against the marker. A row that holds the marker in every column is taken as a member of the group that opened together.

The result is a membership bitmap with one bit per row, together with its population count and an error flag for group sizes that are not a power of two from 2 to 32. The block never fills the subarray before an attempt. The caller must leave every row holding something other than the marker, normally its complement, before issuing start.

Top module: `gd_group_finder`

## Requirements
- R1: A start pulse is taken only while `busy` is low. Taking it latches bank, subarray and both row indices and raises `busy`. While idle the command output is NOP (code 0).
- R2: Command codes are NOP=0, ACT=1, PRE=2, WR=3, RD=4. In the three cycles after a start is taken, the block issues ACT to row A, PRE, and ACT to row B. It then issues WR to columns 0 up to COLS-1 in consecutive cycles, with `wr_data` equal to MARKER, and then one PRE.
- R3: After that PRE there are T_RP NOP cycles. Then rows 0 to ROWS-1 are read in ascending order. Each row gets one ACT, T_RCD NOP cycles, and for each column from 0 upward one RD followed by NOP cycles until `rd_valid` is seen. Each row ends with one PRE and T_RP NOP cycles.
- R4: The row address on `cmd_row` is {subarray, local row}, and `cmd_bank` holds the latched bank for the whole attempt.
- R5: Bit i of `member_map` is 1 only if all COLS words read back from local row i equal MARKER. A row that matches in only some columns reads as 0.
- R6: `pop_count` equals the number of set bits in `member_map`.
- R7: `count_err` is 1 exactly when `pop_count` is not one of 2, 4, 8, 16, 32.
- R8: `done` is high for exactly one cycle, the cycle after the last row's T_RP gap, and `busy` is low after it. The map, count and flag then hold until the next start is taken, which clears the map.
- R9: A start pulse while `busy` is high has no effect on the command stream or the result.
- R10: After reset the block is idle: `busy`=0, `done`=0, `cmd`=NOP, `member_map`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one discovery attempt |
| start_bank | input | BANK_W | Target bank |
| start_sub | input | SUB_W | Target subarray |
| start_row_a | input | RIDX_W | First row of the pair, local index |
| start_row_b | input | RIDX_W | Second row of the pair, local index |
| busy | output | 1 | Attempt in progress |
| cmd | output | 3 | DRAM command code |
| cmd_bank | output | BANK_W | Bank for the command |
| cmd_row | output | SUB_W+RIDX_W | Row address for ACT |
| cmd_col | output | COL_W | Column for WR and RD |
| wr_data | output | WORD_W | Write data, the marker |
| rd_valid | input | 1 | Read word present on rd_data |
| rd_data | input | WORD_W | Read word |
| member_map | output | ROWS | Bit i set when row i took the marker |
| pop_count | output | POP_W | Set bits in member_map |
| count_err | output | 1 | Group size not a power of two in 2..32 |
| done | output | 1 | One-cycle end-of-attempt pulse |

## Verification
The assertions assume the memory side returns exactly one `rd_valid` for each RD, and never one before that RD. They also assume reset is held for at least one clock. The bench memory model answers each RD with one word on the following cycle. It produces multi-row opening only for an ACT that comes directly after an ACT, PRE pair, so the stimulus stays inside these assumptions. Before every attempt the model fills the subarray with the marker's complement. One run plants a partial marker in a non-member row, and another injects a start while the block is busy.

// File: rtl/gd_pkg.sv
// Package gd_pkg: command codes and sequencer states shared by the
// discovery sequencer modules. Assumes a 3-bit command bus.
package gd_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_PRE = 3'd2,
        CMD_WR  = 3'd3,
        CMD_RD  = 3'd4
    } dram_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_F_ACT1,
        ST_F_PRE,
        ST_F_ACT2,
        ST_F_WR,
        ST_CLOSE,
        ST_GAP_RP,
        ST_R_ACT,
        ST_R_RCD,
        ST_R_RD,
        ST_R_DATA,
        ST_R_PRE,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/gd_sequencer.sv
// gd_sequencer: command sequencer for one discovery attempt. It issues the
// fast ACT/PRE/ACT/WR chain, then scans every row of the subarray with
// nominal gaps. Assumes T_RCD >= 1, T_RP >= 1 and one rd_valid per RD.
module gd_sequencer
    import gd_pkg::*;
#(
    parameter int ROWS  = 32,
    parameter int COLS  = 4,
    parameter int T_RCD = 3,
    parameter int T_RP  = 2,
    localparam int RIDX_W = $clog2(ROWS),
    localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int TMAX   = (T_RCD > T_RP) ? T_RCD : T_RP,
    localparam int WT_W   = $clog2(TMAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RIDX_W-1:0] start_row_a,
    input  logic [RIDX_W-1:0] start_row_b,
    input  logic              rd_valid,
    output dram_cmd_e         cmd,
    output logic [RIDX_W-1:0] cmd_row_local,
    output logic [COL_W-1:0]  cmd_col,
    output logic              accept,
    output logic              busy,
    output logic              done,
    output logic              word_take,
    output logic              word_last,
    output logic [RIDX_W-1:0] scan_row
);

    localparam logic [COL_W-1:0]  LAST_COL = COL_W'(COLS - 1);
    localparam logic [RIDX_W-1:0] LAST_ROW = RIDX_W'(ROWS - 1);

    seq_state_e        state_q;
    logic [RIDX_W-1:0] ra_q, rb_q, row_q;
    logic [COL_W-1:0]  col_q;
    logic [WT_W-1:0]   wait_q;
    logic              fin_q;

    // State, column, row and gap counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ra_q    <= '0;
            rb_q    <= '0;
            row_q   <= '0;
            col_q   <= '0;
            wait_q  <= '0;
            fin_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    ra_q    <= start_row_a;
                    rb_q    <= start_row_b;
                    state_q <= ST_F_ACT1;
                end
                ST_F_ACT1: state_q <= ST_F_PRE;
                ST_F_PRE:  state_q <= ST_F_ACT2;
                ST_F_ACT2: begin
                    col_q   <= '0;
                    state_q <= ST_F_WR;
                end
                ST_F_WR: begin
                    if (col_q == LAST_COL) begin
                        col_q   <= '0;
                        state_q <= ST_CLOSE;
                    end else begin
                        col_q <= col_q + 1'b1;
                    end
                end
                ST_CLOSE: begin
                    row_q   <= '0;
                    fin_q   <= 1'b0;
                    wait_q  <= WT_W'(T_RP);
                    state_q <= ST_GAP_RP;
                end
                ST_GAP_RP: begin
                    if (wait_q == WT_W'(1)) begin
                        state_q <= fin_q ? ST_DONE : ST_R_ACT;
                    end else begin
                        wait_q <= wait_q - 1'b1;
                    end
                end
                ST_R_ACT: begin
                    wait_q  <= WT_W'(T_RCD);
                    state_q <= ST_R_RCD;
                end
                ST_R_RCD: begin
                    if (wait_q == WT_W'(1)) begin
                        col_q   <= '0;
                        state_q <= ST_R_RD;
                    end else begin
                        wait_q <= wait_q - 1'b1;
                    end
                end
                ST_R_RD: state_q <= ST_R_DATA;
                ST_R_DATA: if (rd_valid) begin
                    if (col_q == LAST_COL) begin
                        state_q <= ST_R_PRE;
                    end else begin
                        col_q   <= col_q + 1'b1;
                        state_q <= ST_R_RD;
                    end
                end
                ST_R_PRE: begin
                    if (row_q == LAST_ROW) fin_q <= 1'b1;
                    else                   row_q <= row_q + 1'b1;
                    wait_q  <= WT_W'(T_RP);
                    state_q <= ST_GAP_RP;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Command decode from the current state.
    always_comb begin
        cmd           = CMD_NOP;
        cmd_row_local = '0;
        case (state_q)
            ST_F_ACT1: begin cmd = CMD_ACT; cmd_row_local = ra_q;  end
            ST_F_PRE:  cmd = CMD_PRE;
            ST_F_ACT2: begin cmd = CMD_ACT; cmd_row_local = rb_q;  end
            ST_F_WR:   cmd = CMD_WR;
            ST_CLOSE:  cmd = CMD_PRE;
            ST_R_ACT:  begin cmd = CMD_ACT; cmd_row_local = row_q; end
            ST_R_RD:   cmd = CMD_RD;
            ST_R_PRE:  cmd = CMD_PRE;
            default:   cmd = CMD_NOP;
        endcase
    end

    assign cmd_col   = col_q;
    assign accept    = (state_q == ST_IDLE) && start;
    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_DONE);
    assign word_take = (state_q == ST_R_DATA) && rd_valid;
    assign word_last = (col_q == LAST_COL);
    assign scan_row  = row_q;

endmodule

// File: rtl/gd_row_matcher.sv
// gd_row_matcher: folds read words into a per-row membership bitmap. A row
// is a member only when every one of its words equals the marker. Assumes
// words of one row arrive in a run ending with word_last.
module gd_row_matcher #(
    parameter int              ROWS   = 32,
    parameter int              WORD_W = 16,
    parameter logic [WORD_W-1:0] MARKER = 16'hA5C3,
    localparam int RIDX_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take,
    input  logic              last,
    input  logic [RIDX_W-1:0] row,
    input  logic [WORD_W-1:0] rd_data,
    output logic [ROWS-1:0]   member_map
);

    logic row_ok_q;
    logic hit;

    assign hit = (rd_data == MARKER);

    // Running all-words-match flag and bitmap update at the end of a row.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            member_map <= '0;
            row_ok_q   <= 1'b1;
        end else if (take) begin
            if (last) begin
                member_map[row] <= row_ok_q & hit;
                row_ok_q        <= 1'b1;
            end else begin
                row_ok_q <= row_ok_q & hit;
            end
        end
    end

endmodule

// File: rtl/gd_popcount.sv
// gd_popcount: counts set bits of the membership bitmap and flags sizes
// other than 2, 4, 8, 16 or 32. Purely combinational.
module gd_popcount #(
    parameter int ROWS = 32,
    localparam int POP_W = $clog2(ROWS + 1)
) (
    input  logic [ROWS-1:0]  bitmap,
    output logic [POP_W-1:0] count,
    output logic             bad_size
);

    // Bit sum over the map.
    always_comb begin
        count = '0;
        for (int i = 0; i < ROWS; i++) begin
            count = count + POP_W'(bitmap[i]);
        end
    end

    // Accepted group sizes: single-bit values from 2 to 32.
    always_comb begin
        logic [31:0] c32;
        c32      = 32'(count);
        bad_size = !((c32 >= 32'd2) && (c32 <= 32'd32) && ((c32 & (c32 - 32'd1)) == 32'd0));
    end

endmodule

// File: rtl/gd_group_finder.sv
// gd_group_finder: top of the simultaneous-row group discovery sequencer.
// Latches the target bank and subarray and joins sequencer, matcher and
// counter. Assumes the caller has left the subarray free of the marker.
module gd_group_finder
    import gd_pkg::*;
#(
    parameter int ROWS   = 32,
    parameter int COLS   = 4,
    parameter int WORD_W = 16,
    parameter int BANK_W = 2,
    parameter int SUB_W  = 3,
    parameter int T_RCD  = 3,
    parameter int T_RP   = 2,
    parameter logic [WORD_W-1:0] MARKER = 16'hA5C3,
    localparam int RIDX_W = $clog2(ROWS),
    localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int POP_W  = $clog2(ROWS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [BANK_W-1:0]       start_bank,
    input  logic [SUB_W-1:0]        start_sub,
    input  logic [RIDX_W-1:0]       start_row_a,
    input  logic [RIDX_W-1:0]       start_row_b,
    output logic                    busy,
    output logic [2:0]              cmd,
    output logic [BANK_W-1:0]       cmd_bank,
    output logic [SUB_W+RIDX_W-1:0] cmd_row,
    output logic [COL_W-1:0]        cmd_col,
    output logic [WORD_W-1:0]       wr_data,
    input  logic                    rd_valid,
    input  logic [WORD_W-1:0]       rd_data,
    output logic [ROWS-1:0]         member_map,
    output logic [POP_W-1:0]        pop_count,
    output logic                    count_err,
    output logic                    done
);

    dram_cmd_e         seq_cmd;
    logic [RIDX_W-1:0] row_local;
    logic [RIDX_W-1:0] scan_row;
    logic              accept, word_take, word_last;
    logic [SUB_W-1:0]  sub_q;
    logic [BANK_W-1:0] bank_q;

    // Target bank and subarray held for the whole attempt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
            sub_q  <= '0;
        end else if (accept) begin
            bank_q <= start_bank;
            sub_q  <= start_sub;
        end
    end

    gd_sequencer #(
        .ROWS (ROWS),
        .COLS (COLS),
        .T_RCD(T_RCD),
        .T_RP (T_RP)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .start_row_a  (start_row_a),
        .start_row_b  (start_row_b),
        .rd_valid     (rd_valid),
        .cmd          (seq_cmd),
        .cmd_row_local(row_local),
        .cmd_col      (cmd_col),
        .accept       (accept),
        .busy         (busy),
        .done         (done),
        .word_take    (word_take),
        .word_last    (word_last),
        .scan_row     (scan_row)
    );

    gd_row_matcher #(
        .ROWS  (ROWS),
        .WORD_W(WORD_W),
        .MARKER(MARKER)
    ) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .take      (word_take),
        .last      (word_last),
        .row       (scan_row),
        .rd_data   (rd_data),
        .member_map(member_map)
    );

    gd_popcount #(
        .ROWS(ROWS)
    ) u_pop (
        .bitmap  (member_map),
        .count   (pop_count),
        .bad_size(count_err)
    );

    assign cmd      = seq_cmd;
    assign cmd_bank = bank_q;
    assign cmd_row  = {sub_q, row_local};
    assign wr_data  = MARKER;

endmodule

// File: rtl/gd_group_finder_chk.sv
// gd_group_finder_chk: temporal checks on the discovery sequencer's ports.
// Assumes reset is held for at least one clock before release.
module gd_group_finder_chk #(
    parameter int ROWS   = 32,
    parameter int BANK_W = 2,
    parameter int SUB_W  = 3,
    localparam int RIDX_W = $clog2(ROWS)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic [SUB_W-1:0]        start_sub,
    input logic [RIDX_W-1:0]       start_row_a,
    input logic                    busy,
    input logic [2:0]              cmd,
    input logic [BANK_W-1:0]       cmd_bank,
    input logic [SUB_W+RIDX_W-1:0] cmd_row,
    input logic [ROWS-1:0]         member_map,
    input logic                    done
);

    assert_start_opens_row_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && cmd == 3'd1 && cmd_row == {$past(start_sub), $past(start_row_a)}));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cmd == 3'd0));

    assert_fast_chain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd2 && $past(cmd) == 3'd1) |=> (cmd == 3'd1));

    assert_read_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd4) |=> (cmd == 3'd0));

    assert_bank_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cmd_bank));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_map_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(member_map));

endmodule

bind gd_group_finder gd_group_finder_chk #(
    .ROWS  (ROWS),
    .BANK_W(BANK_W),
    .SUB_W (SUB_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_sub  (start_sub),
    .start_row_a(start_row_a),
    .busy       (busy),
    .cmd        (cmd),
    .cmd_bank   (cmd_bank),
    .cmd_row    (cmd_row),
    .member_map (member_map),
    .done       (done)
);

// File: tb/sim_gd_group_finder.sv
`timescale 1ns/1ps
// Bench: behavioural DRAM model plus a queue of expected commands,
// compared on every clock; results checked at done.
module sim_gd_group_finder;

    localparam int ROWS   = 32;
    localparam int COLS   = 4;
    localparam int WORD_W = 16;
    localparam int BANK_W = 2;
    localparam int SUB_W  = 3;
    localparam int T_RCD  = 3;
    localparam int T_RP   = 2;
    localparam logic [WORD_W-1:0] MARK = 16'hA5C3;
    localparam int RIDX_W = $clog2(ROWS);
    localparam int COL_W  = $clog2(COLS);
    localparam int POP_W  = $clog2(ROWS + 1);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                    rst_n, start, busy, rd_valid, count_err, done;
    logic [BANK_W-1:0]       start_bank, cmd_bank;
    logic [SUB_W-1:0]        start_sub;
    logic [RIDX_W-1:0]       start_row_a, start_row_b;
    logic [2:0]              cmd;
    logic [SUB_W+RIDX_W-1:0] cmd_row;
    logic [COL_W-1:0]        cmd_col;
    logic [WORD_W-1:0]       wr_data, rd_data;
    logic [ROWS-1:0]         member_map;
    logic [POP_W-1:0]        pop_count;

    gd_group_finder #(
        .ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W), .BANK_W(BANK_W),
        .SUB_W(SUB_W), .T_RCD(T_RCD), .T_RP(T_RP), .MARKER(MARK)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_bank(start_bank),
        .start_sub(start_sub), .start_row_a(start_row_a), .start_row_b(start_row_b),
        .busy(busy), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .cmd_col(cmd_col), .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
        .member_map(member_map), .pop_count(pop_count), .count_err(count_err), .done(done)
    );

    int total = 0;
    int bad   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural memory: one subarray, multi-row opening on ACT after ACT,PRE.
    logic [WORD_W-1:0] mem [ROWS][COLS];
    logic [ROWS-1:0]   group_mask;
    logic [ROWS-1:0]   open_mask;
    int                open_row;
    logic [2:0]        h1, h2;

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 = 3'd0; h2 = 3'd0; open_mask = '0; open_row = 0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (cmd == 3'd1) begin
                open_row = int'(cmd_row[RIDX_W-1:0]);
                if (h1 == 3'd2 && h2 == 3'd1) open_mask = group_mask;
                else                          open_mask = ROWS'(1) << open_row;
            end
            if (cmd == 3'd3) begin
                for (int r = 0; r < ROWS; r++)
                    if (open_mask[r]) mem[r][cmd_col] = wr_data;
            end
            rd_valid <= (cmd == 3'd4);
            rd_data  <= mem[open_row][cmd_col];
            h2 = h1;
            h1 = cmd;
        end
    end

    typedef struct {
        logic [2:0]        c;
        logic [RIDX_W-1:0] r;
        logic [COL_W-1:0]  col;
        logic              dn;
        string             req;
    } exp_t;
    exp_t q[$];

    function automatic void push(input logic [2:0] c, input int r, input int col,
                                 input logic dn, input string req);
        exp_t e;
        e.c = c; e.r = RIDX_W'(r); e.col = COL_W'(col); e.dn = dn; e.req = req;
        q.push_back(e);
    endfunction

    // Expected command stream from R2, R3 and R8.
    function automatic void build(input int ra, input int rb);
        q.delete();
        push(3'd1, ra, 0, 0, "R2");
        push(3'd2, 0, 0, 0, "R2");
        push(3'd1, rb, 0, 0, "R2");
        for (int c = 0; c < COLS; c++) push(3'd3, 0, c, 0, "R2");
        push(3'd2, 0, 0, 0, "R2");
        for (int k = 0; k < T_RP; k++) push(3'd0, 0, 0, 0, "R3");
        for (int r = 0; r < ROWS; r++) begin
            push(3'd1, r, 0, 0, "R3");
            for (int k = 0; k < T_RCD; k++) push(3'd0, 0, 0, 0, "R3");
            for (int c = 0; c < COLS; c++) begin
                push(3'd4, 0, c, 0, "R3");
                push(3'd0, 0, 0, 0, "R3");
            end
            push(3'd2, 0, 0, 0, "R3");
            for (int k = 0; k < T_RP; k++) push(3'd0, 0, 0, 0, "R3");
        end
        push(3'd0, 0, 0, 1, "R8");
    endfunction

    task automatic run(input int bank, input int sub, input int ra, input int rb,
                       input logic [ROWS-1:0] mask, input int partial_row,
                       input bit intrude);
        logic [ROWS-1:0] exp_map;
        int              n, idx;
        bit              size_ok;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) mem[r][c] = ~MARK;
        if (partial_row >= 0)
            for (int c = 0; c < COLS - 1; c++) mem[partial_row][c] = MARK;
        group_mask = mask;
        exp_map    = mask;
        n          = $countones(mask);
        size_ok    = (n == 2 || n == 4 || n == 8 || n == 16 || n == 32);
        build(ra, rb);
        start       = 1'b1;
        start_bank  = BANK_W'(bank);
        start_sub   = SUB_W'(sub);
        start_row_a = RIDX_W'(ra);
        start_row_b = RIDX_W'(rb);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R1", "busy after start", busy, 1);
        idx = 0;
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(cmd == e.c, e.req, $sformatf("cmd at step %0d", idx), cmd, e.c);
            if (e.c == 3'd1)
                check(cmd_row == {SUB_W'(sub), e.r}, "R4", "ACT row", cmd_row, {SUB_W'(sub), e.r});
            if (e.c == 3'd3 || e.c == 3'd4)
                check(cmd_col == e.col, e.req, "column", cmd_col, e.col);
            if (e.c == 3'd3)
                check(wr_data == MARK, "R2", "write data", wr_data, MARK);
            if (e.c != 3'd0)
                check(cmd_bank == BANK_W'(bank), "R4", "bank", cmd_bank, bank);
            check(done == e.dn, "R8", "done", done, e.dn);
            if (e.dn) begin
                check(member_map == exp_map, "R5", "member map", member_map, exp_map);
                check(int'(pop_count) == n, "R6", "pop count", pop_count, n);
                check(count_err == !size_ok, "R7", "count error", count_err, !size_ok);
            end
            // R9: a start while busy must leave the rest of the stream as expected
            if (intrude && idx == 20) begin
                start = 1'b1; start_row_a = RIDX_W'(ra ^ 1); start_sub = SUB_W'(sub ^ 1);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            idx++;
        end
        check(busy == 1'b0 && done == 1'b0, "R8", "idle after done", {busy, done}, 0);
        repeat (3) @(negedge clk);
        check(member_map == exp_map, "R8", "map held while idle", member_map, exp_map);
        check(cmd == 3'd0, "R1", "idle command", cmd, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; start_bank = '0; start_sub = '0;
        start_row_a = '0; start_row_b = '0; group_mask = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(busy == 1'b0, "R10", "busy in reset", busy, 0);
        check(done == 1'b0, "R10", "done in reset", done, 0);
        check(cmd == 3'd0, "R10", "cmd in reset", cmd, 0);
        check(member_map == '0, "R10", "map in reset", member_map, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && cmd == 3'd0, "R10", "idle after reset", {busy, cmd}, 0);
        run(1, 2, 3, 5, 32'h0000_0028, -1, 0);   // pair only
        run(2, 5, 0, 1, 32'h0000_000F, -1, 0);   // four rows from the bottom
        run(0, 1, 6, 7, 32'h0000_01C0, -1, 0);   // three rows: R7 error
        run(3, 0, 12, 13, 32'h0000_1000, -1, 0); // one row: R7 error
        run(1, 7, 31, 30, 32'hF000_000F, -1, 0); // eight rows at both edges
        run(2, 3, 10, 11, 32'h0000_0C00, 9, 0);  // R5 partial row 9 stays out
        run(0, 4, 16, 17, 32'h00FF_FF00, -1, 1); // sixteen rows, R9 intrusion
        run(3, 6, 0, 31, 32'hFFFF_FFFF, -1, 0);  // whole subarray
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule